// File: doc/BRIEF.md
# Programmable Performance Event Counter

This block is one hardware performance-monitoring counter driven by a 32-bit event configuration word. Every clock cycle it receives, for the local logical processor and for its sibling, a small occurrence count on each of eight event lanes. The configuration word selects which lanes contribute to the count. It then decides how the selected count advances a 48-bit counter: it can add the count directly, compare it against a threshold, invert that comparison, or count only rising edges of the resulting condition. Counting is gated by the current privilege level and by an enable bit.

Software writes the configuration word and the counter through plain write strobes and reads both back at all times. The event lanes are sampled on every cycle and there is no back-pressure. When the counter wraps from all-ones to zero, a sticky overflow flag is set. If the interrupt bit is set, that flag also drives the interrupt request. Writing the counter clears the flag.

Top module: `perf_event_counter`

## Requirements
- R1: After reset the configuration word, the counter, the overflow flag and the interrupt request all read zero.
- R2: A write to the configuration word or the counter is visible on the read port one clock edge later. Configuration bits keep their positions: 7:0 event code, 15:8 unit mask, 16 user, 17 kernel, 18 edge, 19 pin control (stored and read back only), 20 interrupt, 21 any-thread, 22 enable, 23 invert, 31:24 threshold. A counter write takes priority over counting in the same cycle.
- R3: While the stored enable bit (22) is 0, the counter does not change except by a counter write.
- R4: Lane i responds to event code 0x10 + floor(i/4) and to unit-mask bit i. The selected count is the sum of all lanes whose code matches and whose mask bit is set. Any other code selects a count of zero.
- R5: With a threshold of zero and edge detection off, each enabled, permitted cycle adds the full selected count to the counter. In this mode the invert bit has no effect.
- R6: With a non-zero threshold, the condition for a cycle is "selected count >= threshold", and each enabled, permitted cycle in which the condition holds adds exactly one.
- R7: With a non-zero threshold and the invert bit set, the condition becomes "selected count < threshold".
- R8: With the edge bit set, the counter adds one only when the qualified condition is 1 and was 0 in the previous enabled cycle. With a threshold of zero, the condition is "selected count is non-zero". The edge history is cleared at the edge where enable goes from 0 to 1.
- R9: A cycle counts only when the privilege bit matching the current level is set: kernel (17) at ring 0, user (16) otherwise. Otherwise the qualified condition is 0 and nothing is added.
- R10: With the any-thread bit set, the sibling's selected count is added to the local one. With it clear, the sibling lanes are ignored.
- R11: A wrap past all-ones sets the sticky overflow flag, and only a counter write clears it. The interrupt request equals the flag while bit 20 is set and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word write data |
| cnt_wr | input | 1 | Counter write strobe (also clears overflow) |
| cnt_wdata | input | 48 | Counter write data |
| ev_local | input | 32 | Eight 4-bit per-cycle lane counts, own logical processor, lane i at bits 4i+3:4i |
| ev_sibling | input | 32 | Same lane layout for the sibling logical processor |
| priv_ring0 | input | 1 | 1 when the current privilege level is ring 0 |
| cfg_rdata | output | 32 | Stored configuration word |
| cnt_rdata | output | 48 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
Every internal state this block keeps is visible at the counter read port by the edge after it matters. A wrong lane match, threshold compare or privilege gate shows up as a wrong counter delta at the very next edge. A stale or uncleared edge history shows up as a missing or extra single count on the first cycle of a new run. The bench therefore compares the counter, the flag and the interrupt after every single edge against an arithmetic model. It sweeps lane values, thresholds, privilege combinations and thread modes, so a fault shows within one cycle of the stimulus that exposes it.

// File: rtl/pec_pkg.sv
package pec_pkg;

  typedef struct packed {
    logic [7:0] thresh;
    logic       invert;
    logic       en;
    logic       any_thr;
    logic       irq_en;
    logic       pin_ctl;
    logic       edge_det;
    logic       kern;
    logic       user;
    logic [7:0] umask;
    logic [7:0] evsel;
  } pec_cfg_t;

  localparam logic [7:0] LANE_CODE_BASE = 8'h10;
  localparam int         LANES_PER_CODE = 4;

  function automatic logic [7:0] lane_code(input int idx);
    return LANE_CODE_BASE + 8'(idx / LANES_PER_CODE);
  endfunction

endpackage

// File: rtl/pec_lane_select.sv
module pec_lane_select #(
  parameter int LANES = 8,
  parameter int CW    = 4,
  parameter int LSW   = CW + $clog2(LANES)
) (
  input  logic [LANES*CW-1:0] counts,
  input  logic [7:0]          evsel,
  input  logic [7:0]          umask,
  output logic [LSW-1:0]      sum
);
  import pec_pkg::*;

  logic [CW-1:0] masked [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [7:0] CODE = lane_code(i);
    logic hit;
    assign hit       = (evsel == CODE) && umask[i % 8];
    assign masked[i] = hit ? counts[i*CW +: CW] : '0;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++) sum = sum + LSW'(masked[i]);
  end

endmodule

// File: rtl/pec_event_filter.sv
module pec_event_filter #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hist_clr,
  input  logic [SW-1:0] sum,
  input  logic [7:0]    thresh,
  input  logic          invert,
  input  logic          edge_det,
  input  logic          user,
  input  logic          kern,
  input  logic          en,
  input  logic          priv_ring0,
  output logic [SW-1:0] inc
);
  localparam int CMPW = (SW > 8) ? SW : 8;

  logic [CMPW-1:0] s_ext, t_ext;
  logic allowed, thr_mode, cond, qual, hist;

  assign s_ext = CMPW'(sum);
  assign t_ext = CMPW'(thresh);

  always_comb begin
    allowed  = priv_ring0 ? kern : user;
    thr_mode = (thresh != 8'd0);
    if (thr_mode) cond = invert ? (s_ext < t_ext) : (s_ext >= t_ext);
    else          cond = |sum;
    qual = cond & allowed;
    if (!en)           inc = '0;
    else if (edge_det) inc = SW'(qual & ~hist);
    else if (thr_mode) inc = SW'(qual);
    else               inc = allowed ? sum : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= 1'b0;
    else if (hist_clr) hist <= 1'b0;
    else if (en)       hist <= qual;
  end

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter #(
  parameter int LANES = 8,
  parameter int CW    = 4,
  parameter int CTR_W = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [31:0]         cfg_wdata,
  input  logic                cnt_wr,
  input  logic [CTR_W-1:0]    cnt_wdata,
  input  logic [LANES*CW-1:0] ev_local,
  input  logic [LANES*CW-1:0] ev_sibling,
  input  logic                priv_ring0,
  output logic [31:0]         cfg_rdata,
  output logic [CTR_W-1:0]    cnt_rdata,
  output logic                ovf_flag,
  output logic                irq
);
  import pec_pkg::*;

  localparam int LSW = CW + $clog2(LANES);
  localparam int SW  = LSW + 1;

  pec_cfg_t         cfg, cfg_new;
  logic [CTR_W-1:0] cnt;
  logic             ovf;
  logic [LSW-1:0]   sum_loc, sum_sib;
  logic [SW-1:0]    sum_all, inc;
  logic [CTR_W:0]   nxt;
  logic             hist_clr;

  pec_lane_select #(.LANES(LANES), .CW(CW), .LSW(LSW)) u_sel_loc (
    .counts(ev_local), .evsel(cfg.evsel), .umask(cfg.umask), .sum(sum_loc));

  pec_lane_select #(.LANES(LANES), .CW(CW), .LSW(LSW)) u_sel_sib (
    .counts(ev_sibling), .evsel(cfg.evsel), .umask(cfg.umask), .sum(sum_sib));

  assign sum_all  = SW'(sum_loc) + (cfg.any_thr ? SW'(sum_sib) : '0);
  assign cfg_new  = pec_cfg_t'(cfg_wdata);
  assign hist_clr = cfg_wr && cfg_new.en && !cfg.en;

  pec_event_filter #(.SW(SW)) u_filt (
    .clk(clk), .rst_n(rst_n), .hist_clr(hist_clr), .sum(sum_all),
    .thresh(cfg.thresh), .invert(cfg.invert), .edge_det(cfg.edge_det),
    .user(cfg.user), .kern(cfg.kern), .en(cfg.en),
    .priv_ring0(priv_ring0), .inc(inc));

  assign nxt = {1'b0, cnt} + (CTR_W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (cfg_wr) cfg <= cfg_new;
      if (cnt_wr) begin
        cnt <= cnt_wdata;
        ovf <= 1'b0;
      end else if (cfg.en) begin
        cnt <= nxt[CTR_W-1:0];
        if (nxt[CTR_W]) ovf <= 1'b1;
      end
    end
  end

  assign cfg_rdata = cfg;
  assign cnt_rdata = cnt;
  assign ovf_flag  = ovf;
  assign irq       = ovf & cfg.irq_en;

endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int CTR_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [31:0]      cfg_wdata,
  input logic             cnt_wr,
  input logic [CTR_W-1:0] cnt_wdata,
  input logic             priv_ring0,
  input logic [31:0]      cfg_rdata,
  input logic [CTR_W-1:0] cnt_rdata,
  input logic             ovf_flag,
  input logic             irq
);
  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == $past(cfg_wdata)); // R2
  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_rdata == $past(cnt_wdata)); // R2
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[22] && !cnt_wr) |=> $stable(cnt_rdata)); // R3
  AST_THRESH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[22] && cfg_rdata[31:24] != 8'd0 && !cnt_wr)
      |=> CTR_W'(cnt_rdata - $past(cnt_rdata)) <= CTR_W'(1)); // R6
  AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_ring0 && !cfg_rdata[17] && !cnt_wr) |=> $stable(cnt_rdata)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !cnt_wr) |=> ovf_flag); // R11
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !ovf_flag); // R11
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag && cfg_rdata[20])); // R11
endmodule

bind perf_event_counter pec_checker #(.CTR_W(CTR_W)) u_pec_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .priv_ring0(priv_ring0),
  .cfg_rdata(cfg_rdata), .cnt_rdata(cnt_rdata), .ovf_flag(ovf_flag), .irq(irq));

// File: tb/perf_event_counter_test.sv
module perf_event_counter_test;
  localparam int LANES = 8, CW = 4, CTR_W = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, cnt_wr = 1'b0, priv_ring0 = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [CTR_W-1:0] cnt_wdata = '0;
  logic [LANES*CW-1:0] ev_local, ev_sibling;
  logic [31:0] cfg_rdata;
  logic [CTR_W-1:0] cnt_rdata;
  logic ovf_flag, irq;

  logic [CW-1:0] loc [LANES];
  logic [CW-1:0] sib [LANES];

  int checks = 0, errors = 0;

  logic [31:0]      m_cfg = '0;
  logic [CTR_W-1:0] m_cnt = '0;
  logic             m_ovf = 1'b0, m_hist = 1'b0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < LANES; i++) begin
      ev_local[i*CW +: CW]   = loc[i];
      ev_sibling[i*CW +: CW] = sib[i];
    end

  perf_event_counter #(.LANES(LANES), .CW(CW), .CTR_W(CTR_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ev_local(ev_local),
    .ev_sibling(ev_sibling), .priv_ring0(priv_ring0), .cfg_rdata(cfg_rdata),
    .cnt_rdata(cnt_rdata), .ovf_flag(ovf_flag), .irq(irq));

  function automatic logic [31:0] mk(input logic [7:0] ev, input logic [7:0] um,
      input bit usr, input bit os, input bit edg, input bit intr, input bit any,
      input bit en, input bit inv, input logic [7:0] cm);
    return {cm, inv, en, any, intr, 1'b0, edg, os, usr, um, ev};
  endfunction

  function automatic int sel(input logic [CW-1:0] l [LANES], input logic [31:0] c);
    int s = 0;
    for (int i = 0; i < LANES; i++)
      if (c[7:0] == 8'h10 + 8'(i / 4) && c[8 + i]) s += int'(l[i]);
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit cw, input logic [31:0] cd, input bit nw,
                      input logic [CTR_W-1:0] nd, input bit r0, input string tag);
    int s, inc;
    bit allowed, cond, q;
    logic [CTR_W:0] nx;
    cfg_wr = cw; cfg_wdata = cd; cnt_wr = nw; cnt_wdata = nd; priv_ring0 = r0;
    @(posedge clk);
    s = sel(loc, m_cfg) + (m_cfg[21] ? sel(sib, m_cfg) : 0);
    allowed = r0 ? m_cfg[17] : m_cfg[16];
    if (m_cfg[31:24] == 0) cond = (s != 0);
    else cond = m_cfg[23] ? (s < int'(m_cfg[31:24])) : (s >= int'(m_cfg[31:24]));
    q = cond && allowed;
    if (!m_cfg[22])            inc = 0;
    else if (m_cfg[18])        inc = (q && !m_hist) ? 1 : 0;
    else if (m_cfg[31:24] != 0) inc = q ? 1 : 0;
    else                       inc = allowed ? s : 0;
    if (nw) begin m_cnt = nd; m_ovf = 1'b0; end
    else if (m_cfg[22]) begin
      nx = {1'b0, m_cnt} + (CTR_W+1)'(inc);
      m_cnt = nx[CTR_W-1:0];
      if (nx[CTR_W]) m_ovf = 1'b1;
    end
    if (cw && cd[22] && !m_cfg[22]) m_hist = 1'b0;
    else if (m_cfg[22]) m_hist = q;
    if (cw) m_cfg = cd;
    @(negedge clk);
    cfg_wr = 1'b0; cnt_wr = 1'b0;
    chk(cnt_rdata == m_cnt, {tag, " counter"}, 64'(cnt_rdata), 64'(m_cnt));
    chk(ovf_flag == m_ovf, {tag, " overflow"}, 64'(ovf_flag), 64'(m_ovf));
    chk(irq == (m_ovf & m_cfg[20]), {tag, " irq"}, 64'(irq), 64'(m_ovf & m_cfg[20]));
    chk(cfg_rdata == m_cfg, {tag, " config"}, 64'(cfg_rdata), 64'(m_cfg));
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, '0, priv_ring0, tag);
  endtask

  task automatic wcfg(input logic [31:0] c, input string tag);
    step(1'b1, c, 1'b0, '0, priv_ring0, tag);
  endtask

  task automatic clr_lanes();
    for (int i = 0; i < LANES; i++) begin loc[i] = '0; sib[i] = '0; end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr_lanes();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(cfg_rdata == 0 && cnt_rdata == 0 && !ovf_flag && !irq, "R1 reset",
        {ovf_flag, irq, 30'(cfg_rdata), 32'(cnt_rdata)}, 64'd0);

    // R2 readback, including the pin-control bit
    wcfg(32'hFFB7_FFFF & ~(32'd1 << 22), "R2 cfg write");
    wcfg(32'h0008_0000, "R2 pin bit");
    step(1'b0, '0, 1'b1, 48'h1234_5678_9ABC, 1'b0, "R2 counter write");

    // R3 disabled
    for (int i = 0; i < LANES; i++) loc[i] = 4'd9;
    wcfg(mk(8'h10, 8'hFF, 1, 1, 0, 0, 0, 0, 0, 8'd0), "R3 setup");
    repeat (4) idle("R3 disabled");

    // R5 / R4 full-count sweep
    step(1'b1, mk(8'h10, 8'h0F, 1, 1, 0, 0, 0, 1, 0, 8'd0), 1'b1, '0, 1'b0, "R5 setup");
    for (int a = 0; a < 16; a++) begin
      loc[0] = 4'(a); loc[1] = 4'(15 - a); loc[2] = 4'(a / 2); loc[3] = 4'd1;
      for (int i = 4; i < LANES; i++) loc[i] = 4'd7;
      idle("R5 sum sweep");
    end
    wcfg(mk(8'h10, 8'h0F, 1, 1, 0, 0, 0, 1, 1, 8'd0), "R5 invert ignored");
    idle("R5 invert ignored");

    // R4 lane matching
    wcfg(mk(8'h11, 8'hA0, 1, 1, 0, 0, 0, 1, 0, 8'd0), "R4 upper lanes");
    for (int a = 0; a < 8; a++) begin
      for (int i = 0; i < LANES; i++) loc[i] = 4'((a + i) % 16);
      idle("R4 upper lanes");
    end
    wcfg(mk(8'h10, 8'hF0, 1, 1, 0, 0, 0, 1, 0, 8'd0), "R4 mask miss");
    idle("R4 mask miss");
    wcfg(mk(8'h22, 8'hFF, 1, 1, 0, 0, 0, 1, 0, 8'd0), "R4 code miss");
    idle("R4 code miss");

    // R6 / R7 threshold sweep
    clr_lanes();
    for (int k = 1; k < 10; k++)
      for (int inv = 0; inv < 2; inv++) begin
        wcfg(mk(8'h10, 8'h01, 1, 1, 0, 0, 0, 1, inv[0], 8'(k)),
             inv ? "R7 setup" : "R6 setup");
        for (int v = 0; v < 16; v++) begin
          loc[0] = 4'(v);
          idle(inv ? "R7 inverted threshold" : "R6 threshold");
        end
        loc[0] = '0;
      end

    // R8 edge detection
    wcfg(mk(8'h10, 8'h01, 1, 1, 1, 0, 0, 1, 0, 8'd3), "R8 setup");
    foreach (loc[i]) loc[i] = '0;
    for (int p = 0; p < 10; p++) begin
      loc[0] = (p inside {1, 2, 5, 6, 7, 9}) ? 4'd5 : 4'd1;
      idle("R8 edge pattern");
    end
    wcfg(mk(8'h10, 8'h01, 1, 1, 1, 0, 0, 0, 0, 8'd3), "R8 disable");
    wcfg(mk(8'h10, 8'h01, 1, 1, 1, 0, 0, 1, 0, 8'd3), "R8 re-enable");
    idle("R8 history cleared");
    idle("R8 held high");
    wcfg(mk(8'h10, 8'h01, 1, 1, 1, 0, 0, 1, 0, 8'd0), "R8 zero threshold");
    for (int p = 0; p < 6; p++) begin
      loc[0] = p[0] ? 4'd0 : 4'd2;
      idle("R8 nonzero edges");
    end

    // R9 privilege
    loc[0] = 4'd3;
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 2; r++) begin
        wcfg(mk(8'h10, 8'h01, m[0], m[1], 0, 0, 0, 1, 0, 8'd0), "R9 setup");
        step(1'b0, '0, 1'b0, '0, r[0], "R9 privilege");
        step(1'b0, '0, 1'b0, '0, r[0], "R9 privilege");
      end
    priv_ring0 = 1'b0;

    // R10 any-thread
    for (int a = 0; a < 2; a++) begin
      wcfg(mk(8'h10, 8'h03, 1, 1, 0, 0, a[0], 1, 0, 8'd0), "R10 setup");
      for (int v = 0; v < 8; v++) begin
        loc[0] = 4'(v); sib[0] = 4'(15 - v); sib[1] = 4'(v * 2);
        idle("R10 sibling");
      end
      wcfg(mk(8'h10, 8'h03, 1, 1, 0, 0, a[0], 1, 0, 8'd20), "R10 threshold");
      for (int v = 0; v < 8; v++) begin
        loc[0] = 4'(v); sib[0] = 4'(12); sib[1] = 4'(v);
        idle("R10 sibling threshold");
      end
    end
    clr_lanes();

    // R11 overflow
    wcfg(mk(8'h10, 8'h01, 1, 1, 0, 1, 0, 1, 0, 8'd0), "R11 setup");
    step(1'b0, '0, 1'b1, 48'hFFFF_FFFF_FFFD, 1'b0, "R11 preset");
    loc[0] = 4'd5;
    idle("R11 wrap");
    loc[0] = 4'd0;
    repeat (2) idle("R11 sticky");
    wcfg(mk(8'h10, 8'h01, 1, 1, 0, 0, 0, 1, 0, 8'd0), "R11 irq masked");
    wcfg(mk(8'h10, 8'h01, 1, 1, 0, 1, 0, 1, 0, 8'd0), "R11 irq unmasked");
    step(1'b0, '0, 1'b1, 48'd7, 1'b0, "R11 clear by write");
    idle("R11 after clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule